// File: doc/BRIEF.md
# Systematic Reed-Solomon Stream Encoder

This block turns a stream of 8-bit message symbols into systematic Reed-Solomon codewords of the (255,223) code over GF(2^8). Symbols arrive one per clock under a valid/ready handshake, with flags that mark the first and the final symbol of each block. Every accepted symbol is copied to the codeword output in the same cycle. At the same time it is folded into a 32-stage remainder register built from constant Galois-field multipliers.

Once the message ends, the input is held off for 32 cycles. During that time the remainder is shifted out as parity, and the final parity symbol is flagged. A message shorter than 223 symbols is legal. Its parity is the parity of the same message with zero symbols placed in front of it up to full length. A message that reaches 223 symbols is closed even when its end flag is missing.

Top module: `rs_enc_stream`

## Requirements
- R1: Field arithmetic is GF(2^8) with field polynomial 0x11D and alpha = 0x02. The first symbol sent is the highest-degree coefficient. Every emitted codeword, message followed by parity, evaluates to zero at alpha^0 through alpha^31.
- R2: An accepted symbol (in_valid_i and in_ready_o both high) appears on out_data_o in the same cycle, unmodified, with out_valid_o high and out_par_o low.
- R3: After the cycle that accepts an end-of-block symbol, the next 32 cycles each carry one parity symbol with out_valid_o and out_par_o high. The highest-order remainder stage comes out first.
- R4: in_ready_o is low during all 32 parity cycles and high in every other cycle.
- R5: out_last_o is high only on the 32nd parity symbol of a block.
- R6: A symbol accepted with in_sob_i high starts from a zero remainder, so a block's parity does not depend on earlier blocks.
- R7: A message of L < 223 symbols yields the same 32 parity symbols as the 223-symbol message made of 223-L zero symbols followed by it.
- R8: The 223rd accepted symbol of a block ends the message even when in_eob_i is low.
- R9: A cycle with in_valid_i low inside a message gives out_valid_o low and changes neither the remainder nor the symbol count, whatever in_sob_i, in_eob_i and in_data_i carry.
- R10: After reset, in_ready_o is high and out_valid_o is low while in_valid_i is low.
- R11: A symbol carrying both in_sob_i and in_eob_i forms a complete one-symbol block, followed by its 32 parity symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input symbol valid |
| in_ready_o | output | 1 | Encoder can take a symbol |
| in_data_i | input | 8 | Message symbol |
| in_sob_i | input | 1 | First symbol of a block |
| in_eob_i | input | 1 | Final symbol of a block |
| out_valid_o | output | 1 | Output symbol valid |
| out_data_o | output | 8 | Codeword symbol |
| out_par_o | output | 1 | High while a parity symbol is on the output |
| out_last_o | output | 1 | Final symbol of the codeword |

## Verification
Two operations can fall in the same cycle. One is the remainder clear caused by the start flag, and the other is the switch into the parity phase caused by the end flag. Both fire when a single symbol carries both flags. The bench sends every one of the 256 possible one-symbol blocks back to back after longer blocks. Each result is judged by evaluating the whole codeword at the 32 roots, which gives zero only if the clear and the feedback both acted on that one symbol. A second pairing is the length limit arriving on the same symbol as an explicit end flag. All message lengths from 1 to 223 are swept, and 223 is also sent with no end flag.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

  typedef enum logic {ST_MSG, ST_PAR} enc_state_e;

  // Generic GF(2^w) multiply, w <= 15, field polynomial includes bit w
  function automatic logic [15:0] gf_mul(logic [15:0] a, logic [15:0] b, int w,
                                         logic [16:0] poly);
    logic [15:0] acc;
    logic [16:0] x;
    acc = '0;
    x   = {1'b0, a};
    for (int i = 0; i < 16; i++) begin
      if (i < w) begin
        if (b[i]) acc = acc ^ x[15:0];
        x = x << 1;
        if (x[w]) x = x ^ poly;
      end
    end
    return acc;
  endfunction

  // Coefficient idx of prod_{r<npar} (x + alpha^r), alpha = x
  function automatic logic [15:0] gen_coef(int idx, int npar, int w, logic [16:0] poly);
    logic [15:0] g [0:64];
    logic [15:0] root;
    for (int i = 0; i <= 64; i++) g[i] = '0;
    g[0] = 16'd1;
    root = 16'd1;
    for (int r = 0; r < 64; r++) begin
      if (r < npar) begin
        for (int i = 64; i >= 1; i--) begin
          if (i <= r + 1) g[i] = g[i-1] ^ gf_mul(g[i], root, w, poly);
        end
        g[0] = gf_mul(g[0], root, w, poly);
        root = gf_mul(root, 16'd2, w, poly);
      end
    end
    return g[idx];
  endfunction

endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul #(
  parameter int          SYM_W     = 8,
  parameter logic [16:0] PRIM_POLY = 17'h11D,
  parameter logic [SYM_W-1:0] COEF = '0
) (
  input  logic [SYM_W-1:0] a_i,
  output logic [SYM_W-1:0] y_o
);
  localparam logic [15:0] COEF_W = 16'(COEF);

  logic [15:0] a_w;

  // Constant operand: reduces to an XOR network
  always_comb begin
    a_w = '0;
    a_w[SYM_W-1:0] = a_i;
    y_o = SYM_W'(rs_enc_pkg::gf_mul(a_w, COEF_W, SYM_W, PRIM_POLY));
  end
endmodule

// File: rtl/rs_lfsr.sv
module rs_lfsr #(
  parameter int          SYM_W     = 8,
  parameter int          NPAR      = 32,
  parameter logic [16:0] PRIM_POLY = 17'h11D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             clear_i,
  input  logic             drain_i,
  input  logic [SYM_W-1:0] din_i,
  output logic [SYM_W-1:0] tail_o
);
  logic [NPAR-1:0][SYM_W-1:0] rem_q, rem_d, base, prod;
  logic [SYM_W-1:0]           fb;

  assign base = clear_i ? '0 : rem_q;
  assign fb   = din_i ^ base[NPAR-1];

  for (genvar i = 0; i < NPAR; i++) begin : g_stage
    localparam logic [15:0] COEF_W = rs_enc_pkg::gen_coef(i, NPAR, SYM_W, PRIM_POLY);
    rs_gf_cmul #(
      .SYM_W(SYM_W), .PRIM_POLY(PRIM_POLY), .COEF(COEF_W[SYM_W-1:0])
    ) i_cmul (
      .a_i(fb),
      .y_o(prod[i])
    );
  end

  always_comb begin
    rem_d = rem_q;
    if (shift_i) begin
      rem_d[0] = prod[0];
      for (int i = 1; i < NPAR; i++) rem_d[i] = base[i-1] ^ prod[i];
    end else if (drain_i) begin
      rem_d[0] = '0;
      for (int i = 1; i < NPAR; i++) rem_d[i] = rem_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rem_q <= '0;
    else         rem_q <= rem_d;
  end

  assign tail_o = rem_q[NPAR-1];
endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl #(
  parameter int NPAR    = 32,
  parameter int MAX_MSG = 223
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic in_sob_i,
  input  logic in_eob_i,
  output logic ready_o,
  output logic accept_o,
  output logic clear_o,
  output logic drain_o,
  output logic last_o
);
  import rs_enc_pkg::*;

  localparam int CNT_W  = $clog2(MAX_MSG);
  localparam int PCNT_W = $clog2(NPAR);

  enc_state_e        state_q;
  logic [CNT_W-1:0]  msg_cnt_q, cnt_eff;
  logic [PCNT_W-1:0] par_cnt_q;
  logic              end_msg;

  assign ready_o  = (state_q == ST_MSG);
  assign accept_o = in_valid_i && ready_o;
  assign clear_o  = accept_o && in_sob_i;
  assign cnt_eff  = in_sob_i ? '0 : msg_cnt_q;
  assign end_msg  = accept_o && (in_eob_i || cnt_eff == CNT_W'(MAX_MSG - 1));
  assign drain_o  = (state_q == ST_PAR);
  assign last_o   = drain_o && (par_cnt_q == PCNT_W'(NPAR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_MSG;
      msg_cnt_q <= '0;
      par_cnt_q <= '0;
    end else begin
      if (accept_o) msg_cnt_q <= end_msg ? '0 : cnt_eff + 1'b1;
      case (state_q)
        ST_MSG: if (end_msg) begin
          state_q   <= ST_PAR;
          par_cnt_q <= '0;
        end
        default: begin
          par_cnt_q <= par_cnt_q + 1'b1;
          if (last_o) state_q <= ST_MSG;
        end
      endcase
    end
  end
endmodule

// File: rtl/rs_enc_stream.sv
module rs_enc_stream #(
  parameter int          SYM_W     = 8,
  parameter int          NPAR      = 32,
  parameter int          MAX_MSG   = 223,
  parameter logic [16:0] PRIM_POLY = 17'h11D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [SYM_W-1:0] in_data_i,
  input  logic             in_sob_i,
  input  logic             in_eob_i,
  output logic             out_valid_o,
  output logic [SYM_W-1:0] out_data_o,
  output logic             out_par_o,
  output logic             out_last_o
);
  logic             accept, clear, drain;
  logic [SYM_W-1:0] tail;

  rs_enc_ctrl #(.NPAR(NPAR), .MAX_MSG(MAX_MSG)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(in_valid_i),
    .in_sob_i  (in_sob_i),
    .in_eob_i  (in_eob_i),
    .ready_o   (in_ready_o),
    .accept_o  (accept),
    .clear_o   (clear),
    .drain_o   (drain),
    .last_o    (out_last_o)
  );

  rs_lfsr #(.SYM_W(SYM_W), .NPAR(NPAR), .PRIM_POLY(PRIM_POLY)) i_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(accept),
    .clear_i(clear),
    .drain_i(drain),
    .din_i  (in_data_i),
    .tail_o (tail)
  );

  assign out_valid_o = accept || drain;
  assign out_data_o  = drain ? tail : in_data_i;
  assign out_par_o   = drain;
endmodule

// File: rtl/rs_enc_stream_chk.sv
module rs_enc_stream_chk #(
  parameter int SYM_W   = 8,
  parameter int MAX_MSG = 223
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [SYM_W-1:0] in_data_i,
  input logic             in_sob_i,
  input logic             in_eob_i,
  input logic             out_valid_o,
  input logic [SYM_W-1:0] out_data_o,
  input logic             out_par_o,
  input logic             out_last_o
);
  localparam int CW = $clog2(MAX_MSG + 1);

  logic          acc;
  logic [CW-1:0] seen_q, seen_eff;

  assign acc      = in_valid_i && in_ready_o;
  assign seen_eff = in_sob_i ? '0 : seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         seen_q <= '0;
    else if (out_last_o) seen_q <= '0;
    else if (acc)        seen_q <= seen_eff + 1'b1;
  end

  assert_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> (out_valid_o && !out_par_o && out_data_o == in_data_i));

  assert_drain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_eob_i) |=> (out_par_o && out_valid_o));

  assert_cont_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_par_o && !out_last_o) |=> out_par_o);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_par_o |-> !in_ready_o);

  assert_resume_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |=> in_ready_o);

  assert_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> (out_par_o && out_valid_o));

  assert_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && seen_eff == CW'(MAX_MSG - 1)) |=> out_par_o);

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !out_par_o) |-> !out_valid_o);
endmodule

bind rs_enc_stream rs_enc_stream_chk #(.SYM_W(SYM_W), .MAX_MSG(MAX_MSG)) i_chk (.*);

// File: tb/test_rs_enc_stream.sv
`timescale 1ns/1ps
module test_rs_enc_stream;
  localparam int NPAR = 32;
  localparam int KMAX = 223;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sob = 1'b0, in_eob = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_par, out_last;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  rs_enc_stream i_rs_enc_stream (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sob_i(in_sob), .in_eob_i(in_eob),
    .out_valid_o(out_valid), .out_data_o(out_data),
    .out_par_o(out_par), .out_last_o(out_last)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] cw  [0:254];
  logic [7:0] par [0:31];
  logic [7:0] par_ref [0:31];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = '0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] pat(int seed, int k);
    return 8'((seed + k * 37 + ((k * k) >> 2)) & 8'hFF);
  endfunction

  // R1: every codeword has roots alpha^0..alpha^31
  task automatic check_roots(int n, string req);
    logic [7:0] a = 8'd1;
    int bad = 0;
    logic [7:0] bad_s = '0;
    for (int j = 0; j < NPAR; j++) begin
      logic [7:0] s = '0;
      for (int k = 0; k < n; k++) s = gmul(s, a) ^ cw[k];
      if (s != 0 && bad == 0) begin bad = 1; bad_s = s; end
      a = gmul(a, 8'd2);
    end
    chk(bad == 0, req, bad_s, 0);
  endtask

  task automatic run_block(int len, int seed, bit use_eob, int gap_at, int zlead, string req);
    for (int k = 0; k < len; k++) begin
      logic [7:0] sym;
      sym = (k < zlead) ? 8'h00 : pat(seed, k - zlead);
      if (k == gap_at) begin
        @(negedge clk);
        in_valid = 1'b0; in_sob = 1'b1; in_eob = 1'b1; in_data = 8'hA5;
        #1;
        chk(!out_valid && in_ready, "R9 idle cycle", out_valid, 0);
      end
      @(negedge clk);
      in_valid = 1'b1; in_sob = (k == 0); in_eob = use_eob && (k == len - 1); in_data = sym;
      #1;
      chk(in_ready, "R4 ready in message", in_ready, 1);
      chk(out_valid && !out_par && out_data == sym, "R2 pass-through", out_data, sym);
      cw[k] = out_data;
    end
    for (int p = 0; p < NPAR; p++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sob = 1'b0; in_eob = 1'b0;
      #1;
      chk(!in_ready, "R4 held off in drain", in_ready, 0);
      chk(out_valid && out_par, "R3 parity phase", {out_valid, out_par}, 3);
      chk(out_last == (p == NPAR - 1), "R5 last flag", out_last, p == NPAR - 1);
      cw[len + p] = out_data;
      par[p] = out_data;
    end
    @(negedge clk);
    #1;
    chk(in_ready && !out_valid, "R4 ready after drain", {in_ready, out_valid}, 2);
    check_roots(len + NPAR, req);
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready && !out_valid, "R10 reset state", {in_ready, out_valid}, 2);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(in_ready && !out_valid && !out_par && !out_last, "R10 after reset",
        {in_ready, out_valid, out_par, out_last}, 8);

    // Every message length, back to back (R1, R3, R6)
    for (int len = 1; len <= KMAX; len++) run_block(len, len * 3, 1'b1, -1, 0, "R1 R6 roots by length");

    // One-symbol blocks over all symbol values (R11)
    for (int v = 0; v < 256; v++) run_block(1, v, 1'b1, -1, 0, "R11 one-symbol block");

    // Length limit without end flag (R8)
    run_block(KMAX, 77, 1'b0, -1, 0, "R8 limit closes message");

    // Idle cycles with garbage side inputs inside messages (R9)
    run_block(40, 5, 1'b1, 17, 0, "R9 gap keeps remainder");
    run_block(KMAX, 9, 1'b0, 222, 0, "R9 gap before limit symbol");

    // Shortened equals zero-padded full (R7)
    foreach (par_ref[i]) par_ref[i] = '0;
    for (int t = 0; t < 2; t++) begin
      int l;
      l = (t == 0) ? 5 : 100;
      run_block(l, 200 + t, 1'b1, -1, 0, "R7 shortened roots");
      for (int p = 0; p < NPAR; p++) par_ref[p] = par[p];
      run_block(KMAX, 200 + t, 1'b1, -1, KMAX - l, "R7 padded roots");
      for (int p = 0; p < NPAR; p++)
        chk(par[p] == par_ref[p], "R7 shortened parity match", par[p], par_ref[p]);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule